// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block forms the memory address for word and byte loads and stores, together with the updated base value that some addressing modes write back to the base register. It receives the base register value, a 12-bit immediate, a second register value with a shift amount and a shift kind, and the six function bits of a memory-format instruction. From these it computes an offset, adds it to the base or subtracts it from the base, and then applies one of three indexing modes.

In offset mode the address is the adjusted base and nothing is written back. In pre-index mode the address is the adjusted base, and that same value is written back. In post-index mode the address is the unmodified base, and the adjusted base is written back. The fourth combination of the mode bits is flagged as illegal, and write-back is suppressed. The load and byte indications pass through to the memory stage. By default the results are registered, so they appear one clock after the inputs.

Top module: `mem_agu`

## Requirements
- R1: While rst_n is low, the registered outputs (default OUT_STAGE=1) hold mem_addr=0, wb_val=0, wb_en=0, is_load=0, is_byte=0 and mode_bad=0.
- R2: func_bits[5] is the immediate-bar bit. When it is 0, the offset is imm_ofs zero-extended to 32 bits. When it is 1, the offset is idx_val after the shift in R3.
- R3: shift_kind selects the shift applied to idx_val by shift_amt (0..31): 00 shift left logical, 01 shift right logical, 10 shift right arithmetic, 11 rotate right. An amount of 0 leaves idx_val unchanged for every kind.
- R4: func_bits[3] is the add bit: 1 gives base+offset and 0 gives base-offset, both modulo 2^32. wb_val always carries this adjusted base.
- R5: With func_bits[4] (pre) = 1 and func_bits[1] (write-back) = 0 (offset mode), mem_addr is the adjusted base and wb_en is 0.
- R6: With pre=1 and write-back=1 (pre-index mode), mem_addr is the adjusted base, wb_en is 1 and wb_val equals mem_addr.
- R7: With pre=0 and write-back=0 (post-index mode), mem_addr equals base_val and wb_en is 1 with wb_val equal to the adjusted base.
- R8: With pre=0 and write-back=1, mode_bad is 1, wb_en is 0 and mem_addr equals base_val. mode_bad is 0 in the three legal modes.
- R9: is_load follows func_bits[0] (1 = load) and is_byte follows func_bits[2] (1 = byte access) in every mode.
- R10: With OUT_STAGE=1, outputs reflect the inputs sampled at the previous rising clock edge and hold steady between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_val | input | 32 | Base register value |
| imm_ofs | input | 12 | Unsigned immediate offset |
| idx_val | input | 32 | Register offset before shifting |
| shift_amt | input | 5 | Shift amount for idx_val |
| shift_kind | input | 2 | Shift kind for idx_val |
| func_bits | input | 6 | Function bits: [5] immediate-bar, [4] pre, [3] add, [2] byte, [1] write-back, [0] load |
| mem_addr | output | 32 | Memory address |
| wb_en | output | 1 | Base write-back enable |
| wb_val | output | 32 | Base write-back value |
| is_load | output | 1 | Load (1) or store (0) |
| is_byte | output | 1 | Byte (1) or word (0) access |
| mode_bad | output | 1 | Illegal indexing-mode combination |

## Verification
The assertions assume that every input is stable and known at each rising edge while reset is released. They also assume that the checker's own one-cycle copy of the inputs is the correct reference for the registered outputs; this copy is taken to be valid only after the first edge out of reset. The bench drives every input only on the falling edge, holds it across the next rising edge, and never leaves a field undriven. It therefore stays within these assumptions, including in the illegal-mode and wrap-around cases.

// File: rtl/agu_pkg.sv
package agu_pkg;

   typedef enum logic [1:0] {
      SH_LSL = 2'b00,
      SH_LSR = 2'b01,
      SH_ASR = 2'b10,
      SH_ROR = 2'b11
   } agu_shift_e;

   // indexing mode keyed by {pre, write-back}
   typedef enum logic [1:0] {
      IDX_POST = 2'b00,
      IDX_BAD  = 2'b01,
      IDX_OFS  = 2'b10,
      IDX_PRE  = 2'b11
   } agu_idx_e;

   // field order is fixed by the instruction decoder upstream
   typedef struct packed {
      logic imm_n;
      logic pre;
      logic up;
      logic byte_acc;
      logic wback;
      logic load;
   } agu_func_t;

endpackage

// File: rtl/agu_shifter.sv
module agu_shifter #(
   parameter int DW  = 32,
   parameter int SHW = 5
) (
   input  logic [DW-1:0]  din,
   input  logic [SHW-1:0] amt,
   input  logic [1:0]     kind,
   output logic [DW-1:0]  dout
);
   import agu_pkg::*;

   logic [SHW:0][DW-1:0] stg;
   agu_shift_e           sk;

   assign sk     = agu_shift_e'(kind);
   assign stg[0] = din;

   // log-depth barrel: stage k moves by 2**k when amt[k] is set
   for (genvar k = 0; k < SHW; k++) begin : g_stage
      localparam int S = 1 << k;
      logic [DW-1:0] moved;
      always_comb begin
         case (sk)
            SH_LSL:  moved = {stg[k][DW-1-S:0], {S{1'b0}}};
            SH_LSR:  moved = {{S{1'b0}}, stg[k][DW-1:S]};
            SH_ASR:  moved = {{S{stg[k][DW-1]}}, stg[k][DW-1:S]};
            default: moved = {stg[k][S-1:0], stg[k][DW-1:S]};
         endcase
      end
      assign stg[k+1] = amt[k] ? moved : stg[k];
   end

   assign dout = stg[SHW];

endmodule

// File: rtl/agu_offset_unit.sv
module agu_offset_unit #(
   parameter int DW    = 32,
   parameter int IMM_W = 12
) (
   input  logic [DW-1:0]    base,
   input  logic [IMM_W-1:0] imm,
   input  logic [DW-1:0]    shifted,
   input  logic             imm_n,
   input  logic             up,
   output logic [DW-1:0]    adj
);
   localparam int PAD = DW - IMM_W;

   logic [DW-1:0] ofs;

   assign ofs = imm_n ? shifted : {{PAD{1'b0}}, imm};
   assign adj = up ? (base + ofs) : (base - ofs);

endmodule

// File: rtl/agu_mode_ctl.sv
module agu_mode_ctl (
   input  logic pre,
   input  logic wback,
   output logic addr_adj,
   output logic wb_req,
   output logic illegal
);
   import agu_pkg::*;

   agu_idx_e mode;
   assign mode = agu_idx_e'({pre, wback});

   always_comb begin
      addr_adj = 1'b0;
      wb_req   = 1'b0;
      illegal  = 1'b0;
      case (mode)
         IDX_OFS:  addr_adj = 1'b1;
         IDX_PRE:  begin addr_adj = 1'b1; wb_req = 1'b1; end
         IDX_POST: wb_req = 1'b1;
         default:  illegal = 1'b1;
      endcase
   end

endmodule

// File: rtl/mem_agu.sv
module mem_agu #(
   parameter int DW        = 32,
   parameter int IMM_W     = 12,
   parameter bit OUT_STAGE = 1'b1,
   localparam int SHW      = $clog2(DW)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DW-1:0]    base_val,
   input  logic [IMM_W-1:0] imm_ofs,
   input  logic [DW-1:0]    idx_val,
   input  logic [SHW-1:0]   shift_amt,
   input  logic [1:0]       shift_kind,
   input  logic [5:0]       func_bits,
   output logic [DW-1:0]    mem_addr,
   output logic             wb_en,
   output logic [DW-1:0]    wb_val,
   output logic             is_load,
   output logic             is_byte,
   output logic             mode_bad
);
   import agu_pkg::*;

   if (DW < 8 || (1 << SHW) != DW) begin : g_bad_dw
      $error("mem_agu: DW must be a power of two of at least 8");
   end
   if (IMM_W < 1 || IMM_W >= DW) begin : g_bad_imm
      $error("mem_agu: IMM_W must lie between 1 and DW-1");
   end

   agu_func_t     fn;
   logic [DW-1:0] shifted, adj, addr_c;
   logic          addr_adj, wb_req, illegal;

   assign fn = agu_func_t'(func_bits);

   agu_shifter #(.DW(DW), .SHW(SHW)) u_shift (
      .din  (idx_val),
      .amt  (shift_amt),
      .kind (shift_kind),
      .dout (shifted)
   );

   agu_offset_unit #(.DW(DW), .IMM_W(IMM_W)) u_ofs (
      .base    (base_val),
      .imm     (imm_ofs),
      .shifted (shifted),
      .imm_n   (fn.imm_n),
      .up      (fn.up),
      .adj     (adj)
   );

   agu_mode_ctl u_mode (
      .pre      (fn.pre),
      .wback    (fn.wback),
      .addr_adj (addr_adj),
      .wb_req   (wb_req),
      .illegal  (illegal)
   );

   assign addr_c = addr_adj ? adj : base_val;

   if (OUT_STAGE) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem_addr <= '0;
            wb_val   <= '0;
            wb_en    <= 1'b0;
            is_load  <= 1'b0;
            is_byte  <= 1'b0;
            mode_bad <= 1'b0;
         end else begin
            mem_addr <= addr_c;
            wb_val   <= adj;
            wb_en    <= wb_req;
            is_load  <= fn.load;
            is_byte  <= fn.byte_acc;
            mode_bad <= illegal;
         end
      end
   end else begin : g_comb
      always_comb begin
         mem_addr = addr_c;
         wb_val   = adj;
         wb_en    = wb_req;
         is_load  = fn.load;
         is_byte  = fn.byte_acc;
         mode_bad = illegal;
      end
   end

endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
   parameter int DW        = 32,
   parameter int IMM_W     = 12,
   parameter bit OUT_STAGE = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [DW-1:0]    base_val,
   input logic [IMM_W-1:0] imm_ofs,
   input logic [5:0]       func_bits,
   input logic [DW-1:0]    mem_addr,
   input logic             wb_en,
   input logic [DW-1:0]    wb_val,
   input logic             is_load,
   input logic             is_byte,
   input logic             mode_bad
);
   logic [DW-1:0]    q_base;
   logic [IMM_W-1:0] q_imm;
   logic [5:0]       q_fn;
   logic             q_vld;

   if (OUT_STAGE) begin : g_q
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q_base <= '0;
            q_imm  <= '0;
            q_fn   <= '0;
            q_vld  <= 1'b0;
         end else begin
            q_base <= base_val;
            q_imm  <= imm_ofs;
            q_fn   <= func_bits;
            q_vld  <= 1'b1;
         end
      end

      p_reset_clear_r1: assert property (@(posedge clk)
         !rst_n |=> (mem_addr == '0 && wb_val == '0 && !wb_en && !is_load && !is_byte && !mode_bad));
   end else begin : g_q
      assign q_base = base_val;
      assign q_imm  = imm_ofs;
      assign q_fn   = func_bits;
      assign q_vld  = 1'b1;
   end

   // R2, R4: immediate offset added in post-index mode
   p_imm_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (q_vld && q_fn == 6'b001000) |-> wb_val == q_base + {{(DW-IMM_W){1'b0}}, q_imm});

   p_offset_no_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (q_vld && q_fn[4] && !q_fn[1]) |-> (!wb_en && !mode_bad));

   p_pre_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (q_vld && q_fn[4] && q_fn[1]) |-> (wb_en && wb_val == mem_addr));

   p_post_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (q_vld && !q_fn[4] && !q_fn[1]) |-> (wb_en && mem_addr == q_base));

   p_bad_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (q_vld && !q_fn[4] && q_fn[1]) |-> (mode_bad && !wb_en && mem_addr == q_base));

   p_bad_no_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mode_bad |-> !wb_en);

   p_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
      q_vld |-> (is_load == q_fn[0] && is_byte == q_fn[2]));

endmodule

bind mem_agu agu_chk #(.DW(DW), .IMM_W(IMM_W), .OUT_STAGE(OUT_STAGE)) u_chk (.*);

// File: tb/sim_mem_agu.sv
`timescale 1ns/1ps
module sim_mem_agu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] base_val = '0, idx_val = '0;
   logic [11:0] imm_ofs = '0;
   logic [4:0]  shift_amt = '0;
   logic [1:0]  shift_kind = '0;
   logic [5:0]  func_bits = '0;
   logic [31:0] mem_addr, wb_val;
   logic        wb_en, is_load, is_byte, mode_bad;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   mem_agu u0 (.*);

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] f_shift(logic [31:0] x, logic [1:0] k, int a);
      case (k)
         2'b00:   return x << a;
         2'b01:   return x >> a;
         2'b10:   return $unsigned($signed(x) >>> a);
         default: return (a == 0) ? x : ((x >> a) | (x << (32 - a)));
      endcase
   endfunction

   task automatic drive(logic [31:0] b, logic [11:0] im, logic [31:0] ix,
                        logic [4:0] a, logic [1:0] k, logic [5:0] f);
      @(negedge clk);
      base_val = b; imm_ofs = im; idx_val = ix;
      shift_amt = a; shift_kind = k; func_bits = f;
      @(posedge clk);
      #1;
   endtask

   // apply one vector and compare every output with the model
   task automatic vec(string req, logic [31:0] b, logic [11:0] im, logic [31:0] ix,
                      logic [4:0] a, logic [1:0] k, logic [5:0] f);
      logic [31:0] ofs, adj, ea;
      logic        pre, wb, bad, wbe;
      drive(b, im, ix, a, k, f);
      ofs = f[5] ? f_shift(ix, k, int'(a)) : {20'h0, im};
      adj = f[3] ? b + ofs : b - ofs;
      pre = f[4]; wb = f[1];
      bad = !pre && wb;
      wbe = !bad && !(pre && !wb);
      ea  = pre ? adj : b;
      chk(req, "mem_addr", mem_addr, ea);
      chk(req, "wb_val", wb_val, adj);
      chk(req, "wb_en", {31'h0, wb_en}, {31'h0, wbe});
      chk(req, "mode_bad", {31'h0, mode_bad}, {31'h0, bad});
      chk(req, "is_load", {31'h0, is_load}, {31'h0, f[0]});
      chk(req, "is_byte", {31'h0, is_byte}, {31'h0, f[2]});
   endtask

   task automatic t_reset_r1;
      @(negedge clk);
      rst_n = 1'b0;
      base_val = 32'hDEAD_BEEF; func_bits = 6'b111111; imm_ofs = 12'hFFF;
      @(posedge clk); #1;
      chk("R1", "mem_addr", mem_addr, 32'h0);
      chk("R1", "wb_val", wb_val, 32'h0);
      chk("R1", "flags", {26'h0, wb_en, is_load, is_byte, mode_bad, 2'b00}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_modes_r5_r6_r7;
      // fixed values: base 0x1000, imm 0x10
      drive(32'h1000, 12'h010, 0, 0, 0, 6'b011000);
      chk("R5", "offset addr", mem_addr, 32'h1010);
      chk("R5", "offset wb_en", {31'h0, wb_en}, 32'h0);
      drive(32'h1000, 12'h010, 0, 0, 0, 6'b011010);
      chk("R6", "pre addr", mem_addr, 32'h1010);
      chk("R6", "pre wb_val", wb_val, 32'h1010);
      drive(32'h1000, 12'h010, 0, 0, 0, 6'b001000);
      chk("R7", "post addr", mem_addr, 32'h1000);
      chk("R7", "post wb_val", wb_val, 32'h1010);
      vec("R5", 32'h2000, 12'h0FF, 0, 0, 0, 6'b010001);
      vec("R6", 32'h2000, 12'h0FF, 0, 0, 0, 6'b010011);
      vec("R7", 32'h2000, 12'hABC, 0, 0, 0, 6'b000000);
   endtask

   task automatic t_sign_wrap_r4;
      drive(32'hFFFF_FFF0, 12'h020, 0, 0, 0, 6'b011000);
      chk("R4", "add wrap", mem_addr, 32'h0000_0010);
      drive(32'h0000_0004, 12'h008, 0, 0, 0, 6'b010000);
      chk("R4", "sub wrap", mem_addr, 32'hFFFF_FFFC);
      vec("R4", 32'h8000_0000, 12'hFFF, 0, 0, 0, 6'b000010);
   endtask

   task automatic t_shift_r2_r3;
      // register offset, base 0, add, offset mode: address is shifted idx
      drive(0, 12'h123, 32'h8000_0001, 5'd4, 2'b00, 6'b111000);
      chk("R3", "lsl", mem_addr, 32'h0000_0010);
      drive(0, 12'h123, 32'h8000_0001, 5'd4, 2'b01, 6'b111000);
      chk("R3", "lsr", mem_addr, 32'h0800_0000);
      drive(0, 12'h123, 32'h8000_0001, 5'd4, 2'b10, 6'b111000);
      chk("R3", "asr", mem_addr, 32'hF800_0000);
      drive(0, 12'h123, 32'h8000_0001, 5'd4, 2'b11, 6'b111000);
      chk("R3", "ror", mem_addr, 32'h1800_0000);
      for (int k = 0; k < 4; k++) begin
         drive(32'h40, 12'h0, 32'hC000_0005, 5'd0, 2'(k), 6'b111000);
         chk("R3", "zero amount", mem_addr, 32'hC000_0045);
      end
      // immediate selected: idx ignored
      drive(32'h100, 12'h004, 32'hFFFF_0000, 5'd3, 2'b00, 6'b011000);
      chk("R2", "imm sel", mem_addr, 32'h104);
      for (int i = 0; i < 24; i++) begin
         vec("R2", 32'h1234_0000 + 32'(i * 97), 12'(i * 131), 32'h9E37_79B9 ^ 32'(i << 7),
             5'(i * 7), 2'(i), {1'b1, 1'(i), 1'(i >> 1), 1'b0, 1'b0, 1'(i >> 2)});
      end
   endtask

   task automatic t_bad_r8;
      drive(32'h5000, 12'h044, 0, 0, 0, 6'b001011);
      chk("R8", "bad flag", {31'h0, mode_bad}, 32'h1);
      chk("R8", "bad wb_en", {31'h0, wb_en}, 32'h0);
      chk("R8", "bad addr", mem_addr, 32'h5000);
      vec("R8", 32'h7777_0000, 12'h001, 32'h10, 5'd2, 2'b00, 6'b100110);
   endtask

   task automatic t_flags_r9;
      for (int f = 0; f < 64; f++) vec("R9", 32'h0100_0000, 12'h00C, 32'h30, 5'd1, 2'b01, 6'(f));
   endtask

   task automatic t_latency_r10;
      drive(32'hA000, 12'h001, 0, 0, 0, 6'b011000);
      @(negedge clk);
      base_val = 32'hB000;
      #1;
      chk("R10", "hold before edge", mem_addr, 32'hA001);
      @(posedge clk); #1;
      chk("R10", "update after edge", mem_addr, 32'hB001);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset_r1();
      t_modes_r5_r6_r7();
      t_sign_wrap_r4();
      t_shift_r2_r3();
      t_bad_r8();
      t_flags_r9();
      t_latency_r10();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #50000;
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule